// File: doc/BRIEF.md
# Three-format instruction decoder

This block fetches one 16-bit instruction from a byte-wide memory port and splits it into its fields. A start pulse hands it an instruction address. It reads the byte at that address as the high half and the byte after it as the low half. The two top bits of the halfword select one of three encodings:

- a register form with an 8-bit opcode and two register indices;
- an immediate form with a 2-bit opcode, one register index and an 8-bit immediate;
- a branch form with a 4-bit opcode.

A fixed set of register-form opcodes is followed by a 32-bit extension word. The fetch front end then reads four more bytes, most significant first, before it reports the result.

The memory side is a plain request/ready handshake. The block holds the request and the address and waits for as long as ready stays low. When all bytes of the instruction are in, the block raises a one-cycle valid pulse. The decoded fields stay on the outputs until the next fetch is started. Reset is asserted asynchronously (active low), and its release is synchronised inside the block.

Top module: `halfword_insn_decoder`

## Requirements
- R1: After reset, rd_req, busy and dec_valid are all low.
- R2: A fetch reads, in this order, address pc, then pc+1, and for an extended instruction pc+2 through pc+5. Addresses wrap modulo 2^ADDR_W. dec_word is {byte at pc, byte at pc+1}. dec_ext_word is the four extension bytes with the byte at pc+2 in bits 31:24. dec_ext_word is 0 when no extension is present.
- R3: While rd_req is high and rd_ready is low, rd_addr stays constant and no byte is consumed. A byte is taken in a cycle where both rd_req and rd_ready are high, and rd_data is sampled in that same cycle.
- R4: If bit 15 is 0, dec_fmt is 0 and dec_opcode is bits 15:8. dec_reg_a is bits 7:4, dec_reg_b is bits 3:0, and dec_imm8 is 0.
- R5: If bits 15:14 are 10, dec_fmt is 1 and dec_opcode is bits 13:12 zero-extended. dec_reg_a is bits 11:8, dec_imm8 is bits 7:0, and dec_reg_b is 0. This form is never illegal and never extended.
- R6: If bits 15:14 are 11, dec_fmt is 2 and dec_opcode is bits 13:10 zero-extended. Register and immediate outputs are 0. Branch opcodes 10 to 15 are flagged illegal.
- R7: A register-form instruction with an opcode from {0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30, 0x36, 0x37, 0x38, 0x39} has dec_has_ext=1 and dec_len=6, and it takes six byte reads. Every other instruction has dec_has_ext=0 and dec_len=2, and it takes two byte reads.
- R8: Register-form opcodes 0x00, 0x12 through 0x18, and all opcodes above 0x39 set dec_illegal. Such an instruction has dec_has_ext=0 and dec_len=2.
- R9: dec_valid is high for exactly one cycle: the cycle after the last byte of the instruction is taken. The decoded outputs keep their values after that pulse.
- R10: A start pulse while busy is high is ignored. The fetch in progress keeps its addresses and ends with a single valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch at pc_in (ignored while busy) |
| pc_in | input | ADDR_W | Instruction address |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_data | input | 8 | Byte returned by memory |
| rd_ready | input | 1 | Memory has the byte this cycle |
| busy | output | 1 | Fetch in progress |
| dec_valid | output | 1 | One-cycle pulse: decode complete |
| dec_word | output | 16 | Assembled instruction halfword |
| dec_fmt | output | 2 | Format: 0 register, 1 immediate, 2 branch |
| dec_opcode | output | 8 | Opcode, zero-extended |
| dec_reg_a | output | 4 | First register index |
| dec_reg_b | output | 4 | Second register index |
| dec_imm8 | output | 8 | 8-bit immediate |
| dec_has_ext | output | 1 | Extension word present |
| dec_len | output | LEN_W | Instruction length in bytes |
| dec_illegal | output | 1 | Illegal encoding |
| dec_ext_word | output | XW | Assembled extension word |

## Verification
The bench builds the block with ADDR_W=8 and XW=32. With 8-bit addresses, a 256-byte array covers every address the block can emit. Every leading-byte value is therefore swept, with the low byte, the start address and the stall pattern varied. This reaches all three formats, every register-form opcode, every branch opcode, and fetches whose extension bytes wrap past address 0xFF. A start pulse given in the middle of a stalled fetch is also covered.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  typedef enum logic [1:0] {
    FMT_REG = 2'd0,
    FMT_IMM = 2'd1,
    FMT_BR  = 2'd2
  } insn_fmt_e;

  localparam logic [7:0] REG_OP_MAX = 8'h39;
  localparam logic [3:0] BR_OP_MAX  = 4'd9;

  // Register-form opcodes that are followed by an extension word.
  function automatic logic reg_op_extended(input logic [7:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
      8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

  function automatic logic reg_op_bad(input logic [7:0] op);
    return (op == 8'h00) || ((op >= 8'h12) && (op <= 8'h18)) || (op > REG_OP_MAX);
  endfunction

  function automatic logic word_extended(input logic [15:0] w);
    return !w[15] && reg_op_extended(w[15:8]);
  endfunction

endpackage

// File: rtl/insn_byte_fetch.sv
module insn_byte_fetch
  import insn_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int XW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              rd_ready,
  output logic              busy,
  output logic [15:0]       word_q,
  output logic [XW-1:0]     ext_q,
  output logic              done_q
);

  localparam int XBYTES = XW / 8;
  localparam int TOTAL  = 2 + XBYTES;
  localparam int CW     = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] IDX_LO   = CW'(1);
  localparam logic [CW-1:0] IDX_LAST = CW'(TOTAL - 1);

  typedef enum logic {S_IDLE, S_FETCH} fetch_st_e;

  fetch_st_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [15:0]       word_d;
  logic [XW-1:0]     ext_d;
  logic              done_d;
  logic              st_en, cnt_en, base_en, word_en, ext_en;
  logic              take, ext_now, final_byte;

  assign take       = (state_q == S_FETCH) && rd_ready;
  assign ext_now    = word_extended({word_q[15:8], rd_data});
  assign final_byte = ((cnt_q == IDX_LO) && !ext_now) || (cnt_q == IDX_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    base_d  = base_q;
    word_d  = word_q;
    ext_d   = ext_q;
    done_d  = 1'b0;
    st_en   = 1'b0;
    cnt_en  = 1'b0;
    base_en = 1'b0;
    word_en = 1'b0;
    ext_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_FETCH;
          st_en   = 1'b1;
          base_d  = pc_in;
          base_en = 1'b1;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          ext_d   = '0;
          ext_en  = 1'b1;
        end
      end
      S_FETCH: begin
        if (take) begin
          cnt_d  = cnt_q + CW'(1);
          cnt_en = 1'b1;
          if (cnt_q == '0) begin
            word_d  = {rd_data, word_q[7:0]};
            word_en = 1'b1;
          end else if (cnt_q == IDX_LO) begin
            word_d  = {word_q[15:8], rd_data};
            word_en = 1'b1;
          end else begin
            ext_d  = {ext_q[XW-9:0], rd_data};
            ext_en = 1'b1;
          end
          if (final_byte) begin
            state_d = S_IDLE;
            st_en   = 1'b1;
            done_d  = 1'b1;
          end
        end
      end
      default: begin
        state_d = S_IDLE;
        st_en   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      word_q  <= '0;
      ext_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (st_en)   state_q <= state_d;
      if (cnt_en)  cnt_q   <= cnt_d;
      if (base_en) base_q  <= base_d;
      if (word_en) word_q  <= word_d;
      if (ext_en)  ext_q   <= ext_d;
      done_q <= done_d;
    end
  end

  assign rd_req  = (state_q == S_FETCH);
  assign busy    = rd_req;
  assign rd_addr = base_q + ADDR_W'(cnt_q);

endmodule

// File: rtl/insn_field_decode.sv
module insn_field_decode
  import insn_dec_pkg::*;
#(
  parameter int XW    = 32,
  parameter int LEN_W = 3
) (
  input  logic [15:0]      word,
  output logic [1:0]       fmt,
  output logic [7:0]       opcode,
  output logic [3:0]       reg_a,
  output logic [3:0]       reg_b,
  output logic [7:0]       imm8,
  output logic             has_ext,
  output logic             illegal,
  output logic [LEN_W-1:0] len
);

  localparam int XBYTES = XW / 8;
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(2 + XBYTES);

  always_comb begin
    fmt     = FMT_REG;
    opcode  = '0;
    reg_a   = '0;
    reg_b   = '0;
    imm8    = '0;
    has_ext = 1'b0;
    illegal = 1'b0;
    if (!word[15]) begin
      fmt     = FMT_REG;
      opcode  = word[15:8];
      reg_a   = word[7:4];
      reg_b   = word[3:0];
      has_ext = reg_op_extended(word[15:8]);
      illegal = reg_op_bad(word[15:8]);
    end else if (!word[14]) begin
      fmt    = FMT_IMM;
      opcode = {6'b0, word[13:12]};
      reg_a  = word[11:8];
      imm8   = word[7:0];
    end else begin
      fmt     = FMT_BR;
      opcode  = {4'b0, word[13:10]};
      illegal = (word[13:10] > BR_OP_MAX);
    end
    len = has_ext ? LEN_LONG : LEN_SHORT;
  end

endmodule

// File: rtl/halfword_insn_decoder.sv
module halfword_insn_decoder #(
  parameter  int ADDR_W = 16,
  parameter  int XW     = 32,
  localparam int LEN_W  = $clog2(2 + XW / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              rd_ready,
  output logic              busy,
  output logic              dec_valid,
  output logic [15:0]       dec_word,
  output logic [1:0]        dec_fmt,
  output logic [7:0]        dec_opcode,
  output logic [3:0]        dec_reg_a,
  output logic [3:0]        dec_reg_b,
  output logic [7:0]        dec_imm8,
  output logic              dec_has_ext,
  output logic [LEN_W-1:0]  dec_len,
  output logic              dec_illegal,
  output logic [XW-1:0]     dec_ext_word
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  insn_byte_fetch #(
    .ADDR_W (ADDR_W),
    .XW     (XW)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .pc_in    (pc_in),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_ready (rd_ready),
    .busy     (busy),
    .word_q   (dec_word),
    .ext_q    (dec_ext_word),
    .done_q   (dec_valid)
  );

  insn_field_decode #(
    .XW    (XW),
    .LEN_W (LEN_W)
  ) u_fields (
    .word    (dec_word),
    .fmt     (dec_fmt),
    .opcode  (dec_opcode),
    .reg_a   (dec_reg_a),
    .reg_b   (dec_reg_b),
    .imm8    (dec_imm8),
    .has_ext (dec_has_ext),
    .illegal (dec_illegal),
    .len     (dec_len)
  );

endmodule

// File: rtl/insn_dec_checker.sv
module insn_dec_checker #(
  parameter  int ADDR_W = 16,
  parameter  int XW     = 32,
  localparam int LEN_W  = $clog2(2 + XW / 8 + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic              rd_ready,
  input logic              busy,
  input logic              dec_valid,
  input logic [15:0]       dec_word,
  input logic [1:0]        dec_fmt,
  input logic              dec_has_ext,
  input logic              dec_illegal,
  input logic [LEN_W-1:0]  dec_len,
  input logic [XW-1:0]     dec_ext_word
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr))); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ready) |=> (!rd_req || (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)))); // R2

  AST_EXT_TAIL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_has_ext) |-> (dec_ext_word[7:0] == $past(rd_data))); // R2

  AST_FMT_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ((dec_fmt == 2'd0) == !dec_word[15])); // R4

  AST_IMM_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_fmt == 2'd1) |-> (!dec_illegal && !dec_has_ext)); // R5

  AST_BAD_IS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_illegal) |-> (!dec_has_ext && dec_len == LEN_W'(2))); // R8

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R9

  AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(rd_req && rd_ready)); // R9

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rd_ready) |=> busy); // R10

endmodule

bind halfword_insn_decoder insn_dec_checker #(
  .ADDR_W (ADDR_W),
  .XW     (XW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .rd_req       (rd_req),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .rd_ready     (rd_ready),
  .busy         (busy),
  .dec_valid    (dec_valid),
  .dec_word     (dec_word),
  .dec_fmt      (dec_fmt),
  .dec_has_ext  (dec_has_ext),
  .dec_illegal  (dec_illegal),
  .dec_len      (dec_len),
  .dec_ext_word (dec_ext_word)
);

// File: tb/sim_halfword_insn_decoder.sv
module sim_halfword_insn_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int XW = 32;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] pc_in = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          rd_ready = 1'b1;
  logic          busy, dec_valid, dec_has_ext, dec_illegal;
  logic [15:0]   dec_word;
  logic [1:0]    dec_fmt;
  logic [7:0]    dec_opcode, dec_imm8;
  logic [3:0]    dec_reg_a, dec_reg_b;
  logic [LW-1:0] dec_len;
  logic [XW-1:0] dec_ext_word;

  logic [7:0] mem [0:255];
  int checks = 0, fails = 0;
  int total_rd = 0, addr_err = 0, vld_cnt = 0;
  int base_rd = 0, tick = 0;
  logic [7:0] exp_base = '0;
  bit stall_mode = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  halfword_insn_decoder #(.ADDR_W(AW), .XW(XW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .busy(busy), .dec_valid(dec_valid), .dec_word(dec_word), .dec_fmt(dec_fmt),
    .dec_opcode(dec_opcode), .dec_reg_a(dec_reg_a), .dec_reg_b(dec_reg_b),
    .dec_imm8(dec_imm8), .dec_has_ext(dec_has_ext), .dec_len(dec_len),
    .dec_illegal(dec_illegal), .dec_ext_word(dec_ext_word)
  );

  assign rd_data = mem[rd_addr];

  always @(negedge clk) begin
    tick <= tick + 1;
    rd_ready <= !stall_mode || (tick % 3 == 2);
  end

  always @(posedge clk) begin
    if (rd_req && rd_ready) begin
      if (rd_addr !== 8'(exp_base + 8'(total_rd - base_rd))) addr_err = addr_err + 1;
      total_rd = total_rd + 1;
    end
    if (dec_valid) vld_cnt = vld_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ext_listed(input logic [7:0] op);
    return op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B, 8'h1D,
                      8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39};
  endfunction

  task automatic run_insn(input logic [7:0] pc, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [31:0] ext, input bit stall);
    int n;
    int rd0, err0;
    logic [1:0]  e_fmt;
    logic [7:0]  e_op, e_imm;
    logic [3:0]  e_ra, e_rb;
    bit          e_ext, e_ill;
    logic [31:0] e_word;
    string       rq, rqi;
    mem[pc] = hi;
    mem[8'(pc + 1)] = lo;
    mem[8'(pc + 2)] = ext[31:24];
    mem[8'(pc + 3)] = ext[23:16];
    mem[8'(pc + 4)] = ext[15:8];
    mem[8'(pc + 5)] = ext[7:0];
    stall_mode = stall;
    exp_base = pc;
    base_rd = total_rd;
    rd0 = total_rd;
    err0 = addr_err;
    @(negedge clk);
    start = 1'b1;
    pc_in = pc;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!dec_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(dec_valid === 1'b1, "R9 valid seen", 32'(dec_valid), 1);

    e_ra = 0; e_rb = 0; e_imm = 0; e_ext = 0; e_ill = 0;
    if (!hi[7]) begin
      e_fmt = 0; e_op = hi; e_ra = lo[7:4]; e_rb = lo[3:0];
      e_ext = ext_listed(hi);
      e_ill = (hi == 8'h00) || (hi >= 8'h12 && hi <= 8'h18) || (hi > 8'h39);
      rq = "R4"; rqi = "R8";
    end else if (!hi[6]) begin
      e_fmt = 1; e_op = {6'b0, hi[5:4]}; e_ra = hi[3:0]; e_imm = lo;
      rq = "R5"; rqi = "R5";
    end else begin
      e_fmt = 2; e_op = {4'b0, hi[5:2]};
      e_ill = (hi[5:2] > 4'd9);
      rq = "R6"; rqi = "R6";
    end
    e_word = e_ext ? ext : 32'h0;

    chk(dec_word === {hi, lo}, "R2 halfword", 32'(dec_word), 32'({hi, lo}));
    chk(dec_ext_word === e_word, "R2 ext word", dec_ext_word, e_word);
    chk(addr_err == err0, "R2 read addresses", 32'(addr_err - err0), 0);
    chk(dec_fmt === e_fmt, {rq, " fmt"}, 32'(dec_fmt), 32'(e_fmt));
    chk(dec_opcode === e_op, {rq, " opcode"}, 32'(dec_opcode), 32'(e_op));
    chk(dec_reg_a === e_ra, {rq, " reg_a"}, 32'(dec_reg_a), 32'(e_ra));
    chk(dec_reg_b === e_rb, {rq, " reg_b"}, 32'(dec_reg_b), 32'(e_rb));
    chk(dec_imm8 === e_imm, {rq, " imm8"}, 32'(dec_imm8), 32'(e_imm));
    chk(dec_illegal === e_ill, {rqi, " illegal"}, 32'(dec_illegal), 32'(e_ill));
    chk(dec_has_ext === e_ext, "R7 has_ext", 32'(dec_has_ext), 32'(e_ext));
    chk(dec_len === (e_ext ? 3'd6 : 3'd2), "R7 len", 32'(dec_len), e_ext ? 6 : 2);
    chk((total_rd - rd0) == (e_ext ? 6 : 2), "R7 read count", 32'(total_rd - rd0), e_ext ? 6 : 2);
    @(negedge clk);
    chk(dec_valid === 1'b0, "R9 pulse width", 32'(dec_valid), 0);
    chk(dec_word === {hi, lo}, "R9 hold", 32'(dec_word), 32'({hi, lo}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v0, r0, e0;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 13 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    chk(rd_req === 1'b0, "R1 rd_req", 32'(rd_req), 0);
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(dec_valid === 1'b0, "R1 dec_valid", 32'(dec_valid), 0);

    // Sweep every leading byte (R4 R5 R6 R7 R8), with and without stalls (R3)
    for (int i = 0; i < 256; i++)
      run_insn(8'(i * 3), 8'(i), 8'(i * 7 + 3),
               {8'(i), 8'(~i), 8'(i ^ 8'hA5), 8'h3C}, i[0]);

    // Register fields of the register and immediate forms with varied low bytes
    for (int j = 0; j < 32; j++) begin
      run_insn(8'(j * 5 + 40), 8'h05, 8'(j * 9 + j), 32'h0, j[1]);
      run_insn(8'(j * 5 + 41), 8'(8'hA0 | j[3:0]), 8'(255 - j * 8), 32'h0, j[0]);
    end

    // R2: extension bytes wrap past the top of the address space
    run_insn(8'hFC, 8'h01, 8'h2E, 32'hDEADBEEF, 1'b1);
    run_insn(8'hFF, 8'h39, 8'h71, 32'h01234567, 1'b0);

    // R10: start while busy is ignored
    mem[8'h60] = 8'h1A; mem[8'h61] = 8'h45;
    mem[8'h62] = 8'h11; mem[8'h63] = 8'h22; mem[8'h64] = 8'h33; mem[8'h65] = 8'h44;
    stall_mode = 1'b1;
    exp_base = 8'h60;
    base_rd = total_rd;
    v0 = vld_cnt; r0 = total_rd; e0 = addr_err;
    @(negedge clk);
    start = 1'b1; pc_in = 8'h60;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; pc_in = 8'h90;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    chk((vld_cnt - v0) == 1, "R10 single valid", 32'(vld_cnt - v0), 1);
    chk(addr_err == e0, "R10 addresses kept", 32'(addr_err - e0), 0);
    chk((total_rd - r0) == 6, "R10 read count", 32'(total_rd - r0), 6);
    chk(dec_word === 16'h1A45, "R10 word", 32'(dec_word), 32'h1A45);
    chk(dec_ext_word === 32'h11223344, "R10 ext word", dec_ext_word, 32'h11223344);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule